// File: doc/BRIEF.md
# Dual-geometry QoS mapping table

This block holds the QoS remapping entries that a packet classifier uses to replace a frame's priority, DSCP code point, color, GEM port id and queue number. One storage array is presented in two shapes. With the view bit set, software sees a small number of tables, each addressed by a 6-bit DSCP code point. With the view bit clear, it sees many short tables, each addressed by a 3-bit priority. The two shapes occupy separate regions of the array, so an entry in one view never aliases an entry in the other.

Software works through two registers. It first loads an index register with a line, a table number and the view bit. It then reads the addressed entry through the data register, or writes a new value there. A second, read-only port serves a lookup engine. That port takes a view, a table and a line, and returns the entry one clock later, already split into its five fields. After reset a sweep clears the whole array. The block flags that it is ready only when the sweep has finished.

Top module: `qos_map_table`

## Requirements
- R1: After reset is released, `ready` stays low for exactly DEPTH rising edges (1024 by default) and then stays high. At that point every entry in both views reads zero.
- R2: A cycle with `idx_wr` high loads the index register from `idx_wdata`. The line is in bits [5:0], the table number in bits [11:6] and the view bit in bit 12.
- R3: View bit 1 selects the DSCP view: DSCP_TBLS tables (8 by default) of 64 lines. Any 6-bit line is valid in this view.
- R4: View bit 0 selects the priority view: PRI_TBLS tables (64 by default) of 8 lines.
- R5: The two views are disjoint. Each of the 1024 distinct (view, table, line) entries keeps its own value.
- R6: A cycle with `dat_wr` high and `ready` high stores `dat_wdata` into the entry that the index register held before that edge. `dat_rdata` shows the addressed entry combinationally.
- R7: An out-of-range index is ignored on write and reads back as zero. This covers a DSCP table number of DSCP_TBLS or more, a priority table number of PRI_TBLS or more, and a priority line of 8 or more. Such an index leaves every stored entry unchanged. A lookup with such an address also returns zero.
- R8: A lookup presented with `lk_valid` appears on the lookup outputs after the next rising edge, together with `lk_rvalid`. The word is split as follows: priority [2:0], DSCP [8:3], color [11:9], GEM port id [23:12], queue [31:24]. While `lk_valid` is low, the outputs hold.
- R9: If a register write and a lookup hit the same entry in the same cycle, the lookup returns the newly written value.
- R10: While `ready` is low, data writes are ignored. During that time `dat_rdata` reads zero and lookups return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the index register |
| idx_wdata | input | 13 | Index value: line, table, view bit |
| dat_wr | input | 1 | Write the addressed entry |
| dat_wdata | input | 32 | Entry value to write |
| dat_rdata | output | 32 | Addressed entry, zero if out of range or not ready |
| ready | output | 1 | Clear sweep finished |
| lk_valid | input | 1 | Lookup request |
| lk_sel | input | 1 | Lookup view: 1 DSCP, 0 priority |
| lk_tbl | input | 6 | Lookup table number |
| lk_line | input | 6 | Lookup line |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_prio | output | 3 | Looked-up priority |
| lk_dscp | output | 6 | Looked-up DSCP |
| lk_color | output | 3 | Looked-up color |
| lk_gem | output | 12 | Looked-up GEM port id |
| lk_queue | output | 8 | Looked-up queue number |

## Verification
The properties assume that every input is a known value once reset is released. The forwarding property also assumes that the index register is not reloaded in the same cycle as the data write it qualifies. The bench never combines an index load with a data write: it loads the index in one cycle and writes data in the next. It also keeps lookups apart from register traffic, except in the deliberate same-entry and neighbouring-entry collision cases. Every entry of both views is given a distinct value, so any aliasing between the views shows up as a mismatch.

// File: rtl/qos_map_table.sv
module qos_map_table #(
  parameter int DSCP_TBLS = 8,
  parameter int PRI_TBLS  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic [12:0] idx_wdata,
  input  logic        dat_wr,
  input  logic [31:0] dat_wdata,
  output logic [31:0] dat_rdata,
  output logic        ready,
  input  logic        lk_valid,
  input  logic        lk_sel,
  input  logic [5:0]  lk_tbl,
  input  logic [5:0]  lk_line,
  output logic        lk_rvalid,
  output logic [2:0]  lk_prio,
  output logic [5:0]  lk_dscp,
  output logic [2:0]  lk_color,
  output logic [11:0] lk_gem,
  output logic [7:0]  lk_queue
);
  localparam int PRI_LINES  = 8;
  localparam int DSCP_LINES = 64;
  localparam int PRI_SZ     = PRI_TBLS * PRI_LINES;
  localparam int DEPTH      = PRI_SZ + DSCP_TBLS * DSCP_LINES;
  localparam int AW         = $clog2(DEPTH);

  function automatic logic in_range(logic sel, logic [5:0] tbl, logic [5:0] line);
    if (sel) return int'(tbl) < DSCP_TBLS;
    return (int'(tbl) < PRI_TBLS) && (int'(line) < PRI_LINES);
  endfunction

  function automatic logic [AW-1:0] to_addr(logic sel, logic [5:0] tbl, logic [5:0] line);
    int a;
    if (sel) a = PRI_SZ + int'(tbl) * DSCP_LINES + int'(line);
    else     a = int'(tbl) * PRI_LINES + int'(line);
    return AW'(a);
  endfunction

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] sw_cnt;
  logic [12:0]   idx_q;
  logic [31:0]   lk_q;

  wire            idx_sel  = idx_q[12];
  wire [5:0]      idx_tbl  = idx_q[11:6];
  wire [5:0]      idx_line = idx_q[5:0];
  wire            idx_ok   = in_range(idx_sel, idx_tbl, idx_line);
  wire [AW-1:0]   idx_addr = to_addr(idx_sel, idx_tbl, idx_line);
  wire            lk_ok    = in_range(lk_sel, lk_tbl, lk_line);
  wire [AW-1:0]   lk_addr  = to_addr(lk_sel, lk_tbl, lk_line);
  wire            wr_en    = ready & dat_wr & idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_cnt <= '0;
      ready  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (!ready) begin
        sw_cnt <= sw_cnt + 1'b1;
        if (sw_cnt == AW'(DEPTH - 1)) ready <= 1'b1;
      end
      if (idx_wr) idx_q <= idx_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!ready)     mem[sw_cnt]   <= '0;
    else if (wr_en) mem[idx_addr] <= dat_wdata;
  end

  assign dat_rdata = (ready && idx_ok) ? mem[idx_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_rvalid <= 1'b0;
      lk_q      <= '0;
    end else begin
      lk_rvalid <= lk_valid;
      if (lk_valid) begin
        if (!(ready && lk_ok))                lk_q <= '0;
        else if (wr_en && lk_addr == idx_addr) lk_q <= dat_wdata;
        else                                  lk_q <= mem[lk_addr];
      end
    end
  end

  assign lk_prio  = lk_q[2:0];
  assign lk_dscp  = lk_q[8:3];
  assign lk_color = lk_q[11:9];
  assign lk_gem   = lk_q[23:12];
  assign lk_queue = lk_q[31:24];
endmodule

// File: rtl/qos_map_table_chk.sv
module qos_map_table_chk #(
  parameter int DSCP_TBLS = 8,
  parameter int PRI_TBLS  = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic [12:0] idx_q,
  input logic        dat_wr,
  input logic [31:0] dat_wdata,
  input logic [31:0] dat_rdata,
  input logic        lk_valid,
  input logic        lk_sel,
  input logic [5:0]  lk_tbl,
  input logic [5:0]  lk_line,
  input logic        lk_rvalid,
  input logic [2:0]  lk_prio,
  input logic [5:0]  lk_dscp,
  input logic [2:0]  lk_color,
  input logic [11:0] lk_gem,
  input logic [7:0]  lk_queue
);
  wire [31:0] lk_word = {lk_queue, lk_gem, lk_color, lk_dscp, lk_prio};
  wire lk_bad = lk_sel ? (int'(lk_tbl) >= DSCP_TBLS)
                       : ((int'(lk_tbl) >= PRI_TBLS) || (lk_line >= 6'd8));
  wire same_entry = (lk_sel == idx_q[12]) && (lk_tbl == idx_q[11:6]) && (lk_line == idx_q[5:0]);

  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> dat_rdata == 32'd0);
  p_idle_lookup_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && lk_valid) |=> lk_word == 32'd0);
  p_rvalid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rvalid);
  p_rvalid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rvalid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(lk_word));
  p_oor_lookup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_bad) |=> lk_word == 32'd0);
  p_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && dat_wr && lk_valid && !lk_bad && same_entry) |=> lk_word == $past(dat_wdata));
endmodule

bind qos_map_table qos_map_table_chk #(.DSCP_TBLS(DSCP_TBLS), .PRI_TBLS(PRI_TBLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .idx_q(idx_q), .dat_wr(dat_wr),
  .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .lk_valid(lk_valid), .lk_sel(lk_sel),
  .lk_tbl(lk_tbl), .lk_line(lk_line), .lk_rvalid(lk_rvalid), .lk_prio(lk_prio),
  .lk_dscp(lk_dscp), .lk_color(lk_color), .lk_gem(lk_gem), .lk_queue(lk_queue)
);

// File: tb/test_qos_map_table.sv
module test_qos_map_table;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic clk = 0, rst_n = 0;
  logic idx_wr = 0, dat_wr = 0, lk_valid = 0, lk_sel = 0;
  logic [12:0] idx_wdata = '0;
  logic [31:0] dat_wdata = '0, dat_rdata;
  logic [5:0] lk_tbl = '0, lk_line = '0;
  logic ready, lk_rvalid;
  logic [2:0] lk_prio, lk_color;
  logic [5:0] lk_dscp;
  logic [11:0] lk_gem;
  logic [7:0] lk_queue;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qos_map_table i_qos_map_table (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .ready(ready),
    .lk_valid(lk_valid), .lk_sel(lk_sel), .lk_tbl(lk_tbl), .lk_line(lk_line),
    .lk_rvalid(lk_rvalid), .lk_prio(lk_prio), .lk_dscp(lk_dscp), .lk_color(lk_color),
    .lk_gem(lk_gem), .lk_queue(lk_queue)
  );

  wire [31:0] lk_word = {lk_queue, lk_gem, lk_color, lk_dscp, lk_prio};

  function automatic logic [31:0] pat(int sel, int t, int l);
    logic [31:0] k = 32'(sel * 4096 + t * 64 + l + 1);
    return (k * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_idx(int sel, int t, int l);
    @(negedge clk);
    idx_wr = 1; idx_wdata = {1'(sel), 6'(t), 6'(l)};
    @(negedge clk);
    idx_wr = 0;
  endtask

  task automatic wr_entry(int sel, int t, int l, logic [31:0] d);
    set_idx(sel, t, l);
    dat_wr = 1; dat_wdata = d;
    @(negedge clk);
    dat_wr = 0;
  endtask

  task automatic rd_reg(int sel, int t, int l, output logic [31:0] v);
    set_idx(sel, t, l);
    #1 v = dat_rdata;
  endtask

  task automatic lookup(int sel, int t, int l, output logic [31:0] v);
    @(negedge clk);
    lk_valid = 1; lk_sel = 1'(sel); lk_tbl = 6'(t); lk_line = 6'(l);
    @(negedge clk);
    lk_valid = 0;
    #1 v = lk_word;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    #(CLK_PERIOD * 3);
    chk("R1 reset ready", 32'(ready), 0);
    chk("R8 reset rvalid", 32'(lk_rvalid), 0);
    @(negedge clk);
    rst_n = 1;
    n = 0;
    while (!ready) begin
      if (n == 5) begin
        idx_wr = 1; idx_wdata = 13'h0000;
        @(negedge clk); n++;
        idx_wr = 0; dat_wr = 1; dat_wdata = 32'hDEADBEEF; lk_valid = 1;
        lk_sel = 0; lk_tbl = 0; lk_line = 0;
        @(negedge clk); n++;
        dat_wr = 0; lk_valid = 0;
        #1 chk("R10 read while sweeping", dat_rdata, 0);
        chk("R10 lookup while sweeping", lk_word, 0);
      end else begin
        @(negedge clk); n++;
      end
    end
    chk("R1 sweep length", n, DEPTH);

    for (int t = 0; t < 8; t++) begin
      rd_reg(1, 7, t * 9, v); chk("R1 cleared dscp", v, 0);
      rd_reg(0, t * 9, t, v); chk("R1 cleared prio", v, 0);
    end
    rd_reg(0, 0, 0, v); chk("R10 write during sweep ignored", v, 0);

    for (int t = 0; t < 8; t++)
      for (int l = 0; l < 64; l++) wr_entry(1, t, l, pat(1, t, l));
    for (int t = 0; t < 64; t++)
      for (int l = 0; l < 8; l++) wr_entry(0, t, l, pat(0, t, l));

    for (int t = 0; t < 8; t++)
      for (int l = 0; l < 64; l++) begin
        rd_reg(1, t, l, v); chk("R3 R5 R6 dscp view readback", v, pat(1, t, l));
      end
    for (int t = 0; t < 64; t++)
      for (int l = 0; l < 8; l++) begin
        rd_reg(0, t, l, v); chk("R4 R5 R6 prio view readback", v, pat(0, t, l));
      end
    for (int t = 0; t < 8; t++)
      for (int l = 0; l < 64; l++) begin
        lookup(1, t, l, v); chk("R8 dscp lookup", v, pat(1, t, l));
      end
    for (int t = 0; t < 64; t++)
      for (int l = 0; l < 8; l++) begin
        lookup(0, t, l, v); chk("R8 prio lookup", v, pat(0, t, l));
      end

    wr_entry(1, 2, 33, 32'h8DABC52B);
    lookup(1, 2, 33, v);
    chk("R8 rvalid", 32'(lk_rvalid), 1);
    chk("R8 prio field", 32'(lk_prio), 32'h8DABC52B & 32'h7);
    chk("R8 dscp field", 32'(lk_dscp), (32'h8DABC52B >> 3) & 32'h3F);
    chk("R8 color field", 32'(lk_color), (32'h8DABC52B >> 9) & 32'h7);
    chk("R8 gem field", 32'(lk_gem), (32'h8DABC52B >> 12) & 32'hFFF);
    chk("R8 queue field", 32'(lk_queue), 32'h8DABC52B >> 24);
    @(negedge clk); #1;
    chk("R8 rvalid drops", 32'(lk_rvalid), 0);
    chk("R8 hold while idle", lk_word, 32'h8DABC52B);

    set_idx(0, 0, 0);
    @(negedge clk); #1 chk("R2 index to prio 0/0", dat_rdata, pat(0, 0, 0));
    set_idx(1, 7, 63);
    #1 chk("R2 index to dscp 7/63", dat_rdata, pat(1, 7, 63));

    wr_entry(1, 9, 5, 32'h11111111);
    rd_reg(1, 9, 5, v); chk("R7 oor dscp table reads zero", v, 0);
    rd_reg(0, 8, 5, v); chk("R7 oor dscp write no alias", v, pat(0, 8, 5));
    wr_entry(0, 2, 9, 32'h22222222);
    rd_reg(0, 2, 9, v); chk("R7 oor prio line reads zero", v, 0);
    rd_reg(0, 3, 1, v); chk("R7 oor prio write no alias", v, pat(0, 3, 1));
    lookup(1, 20, 0, v); chk("R7 oor dscp lookup", v, 0);
    lookup(0, 5, 12, v); chk("R7 oor prio lookup", v, 0);

    set_idx(1, 3, 10);
    dat_wr = 1; dat_wdata = 32'hCAFEF00D;
    lk_valid = 1; lk_sel = 1; lk_tbl = 3; lk_line = 10;
    @(negedge clk);
    dat_wr = 0; lk_valid = 0;
    #1 chk("R9 forward same entry", lk_word, 32'hCAFEF00D);
    set_idx(1, 3, 10);
    dat_wr = 1; dat_wdata = 32'h0BADF00D;
    lk_valid = 1; lk_sel = 1; lk_tbl = 3; lk_line = 11;
    @(negedge clk);
    dat_wr = 0; lk_valid = 0;
    #1 chk("R9 neighbour not forwarded", lk_word, pat(1, 3, 11));
    rd_reg(1, 3, 10, v); chk("R6 write stored", v, 32'h0BADF00D);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule